// File: doc/BRIEF.md
# Interrupt Controller Initialization Sequencer

This block sits at the processor-facing edge of a priority interrupt controller. It decodes byte writes made with a single address bit, a write strobe and an 8-bit data bus. Out of reset it waits for a start-of-setup byte. It then collects a setup sequence whose length depends on that byte: two, three or four bytes. After that it hands every later write either to the mask register or to the operation-command path.

Its outputs configure the arbiter next to it. They are the five high vector bits, the single/cascade flag, the cascade configuration byte, the five mode bits and the eight-bit request mask. Each time a start byte arrives it also produces two one-cycle reset pulses, one for the request edge detectors and one for the arbiter's mode state. The arbiter interprets the operation-command bytes itself. This block only delivers them as a one-cycle strobe with the byte.

Top module: `irq_init_seq`

## Requirements
- R1: A write with `addr0`=0 and `wr_data[4]`=1 is a start byte. From any state it restarts the sequence, and `ready` is low in the cycle after that write.
- R2: The first write with `addr0`=1 after a start byte loads `vec_base` from `wr_data[7:3]`.
- R3: Start byte bit 1 is the single flag and appears on `single_mode`. A third byte (`addr0`=1) is expected only when that bit is 0, and it loads `cascade_cfg`.
- R4: Start byte bit 0 requests a final byte (`addr0`=1) that loads `mode_bits` from `wr_data[4:0]`. The bit positions are: 0 wide-bus vector format, 1 automatic end of service, 2 master select, 3 buffered, 4 special nesting. When start byte bit 0 is 0, `mode_bits` is all zero in the cycle after the start byte.
- R5: A start byte clears `mask`. It also raises `edge_rst_pulse` and `mode_rst_pulse` for exactly the one cycle after the write.
- R6: `ready` rises in the cycle after the last expected setup byte, and the sequence is two to four bytes long.
- R7: While `ready` is high, a write with `addr0`=0 and `wr_data[4]`=0 raises `ocw_valid` for one cycle and presents the byte on `ocw_data`.
- R8: While `ready` is high, a write with `addr0`=1 loads `mask` from `wr_data`.
- R9: Writes that are not start bytes have no effect on any output in two cases: before the first start byte, and during the sequence when `addr0`=0.
- R10: After reset, `ready`, both pulses, `ocw_valid` and every configuration output are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| addr0 | input | 1 | Address bit selecting the byte's role |
| wr_data | input | 8 | Write data byte |
| ready | output | 1 | Setup complete, requests may be accepted |
| vec_base | output | 5 | High vector bits from the second byte |
| single_mode | output | 1 | 1 = single controller, 0 = cascaded |
| cascade_cfg | output | 8 | Cascade configuration byte |
| mode_bits | output | 5 | Mode bits from the final byte |
| mask | output | 8 | Request mask register |
| edge_rst_pulse | output | 1 | One-cycle reset for edge-sense state |
| mode_rst_pulse | output | 1 | One-cycle reset for arbiter mode state |
| ocw_valid | output | 1 | Operation-command strobe |
| ocw_data | output | 8 | Last operation-command byte |

## Verification
The embedded properties check on every cycle that a start byte drops `ready` and clears the mask. They also check that the pulses and the command strobe appear only after the write that causes them, that the mode bits clear when no final byte is requested, and that the mask changes only through its two legitimate causes. Other behaviours need the bench's scenarios to show them. These are the data-dependent sequence lengths (two, three and four bytes), a restart in the middle of a sequence, the writes that are ignored before and during setup, and the exact values that land in each configuration field.

// File: rtl/irq_init_pkg.sv
package irq_init_pkg;

  typedef enum logic [2:0] {
    ST_UNINIT = 3'd0,
    ST_WANT2  = 3'd1,
    ST_WANT3  = 3'd2,
    ST_WANT4  = 3'd3,
    ST_READY  = 3'd4
  } seq_state_t;

  localparam int INIT_FLAG_BIT = 4;
  localparam int IC4_BIT       = 0;
  localparam int SINGLE_BIT    = 1;
  localparam int BASE_LSB      = 3;

  function automatic logic is_start_byte(input logic a0, input logic flag);
    return (!a0) && flag;
  endfunction

  function automatic seq_state_t after_base(input logic single, input logic ic4);
    if (!single)  return ST_WANT3;
    else if (ic4) return ST_WANT4;
    else          return ST_READY;
  endfunction

  function automatic seq_state_t after_cascade(input logic ic4);
    return ic4 ? ST_WANT4 : ST_READY;
  endfunction

endpackage

// File: rtl/irq_init_fsm.sv
module irq_init_fsm
  import irq_init_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic addr0,
  input  logic init_flag,
  input  logic cfg_single,
  input  logic cfg_ic4,
  output logic ld_first,
  output logic ld_base,
  output logic ld_casc,
  output logic ld_mode,
  output logic ld_mask,
  output logic ld_cmd,
  output logic ready,
  output logic edge_rst_pulse,
  output logic mode_rst_pulse
);

  seq_state_t state_q, state_d;

  // decoded write events, named for the assertions
  always_comb begin
    ld_first = wr_en && is_start_byte(addr0, init_flag);
    ld_base  = wr_en && addr0 && (state_q == ST_WANT2);
    ld_casc  = wr_en && addr0 && (state_q == ST_WANT3);
    ld_mode  = wr_en && addr0 && (state_q == ST_WANT4);
    ld_mask  = wr_en && addr0 && (state_q == ST_READY);
    ld_cmd   = wr_en && !addr0 && !init_flag && (state_q == ST_READY);
  end

  always_comb begin
    state_d = state_q;
    if (ld_first)     state_d = ST_WANT2;
    else if (ld_base) state_d = after_base(cfg_single, cfg_ic4);
    else if (ld_casc) state_d = after_cascade(cfg_ic4);
    else if (ld_mode) state_d = ST_READY;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q        <= ST_UNINIT;
      edge_rst_pulse <= 1'b0;
      mode_rst_pulse <= 1'b0;
    end else begin
      state_q        <= state_d;
      edge_rst_pulse <= ld_first;
      mode_rst_pulse <= ld_first;
    end
  end

  assign ready = (state_q == ST_READY);

  p_first_restarts_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ld_first |=> (!ready && state_q == ST_WANT2));

  p_ready_after_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(ld_base || ld_casc || ld_mode));

  p_uninit_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_UNINIT && !ld_first) |=> state_q == ST_UNINIT);

  p_pulse_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    edge_rst_pulse |-> $past(ld_first));

endmodule

// File: rtl/irq_init_cfg.sv
module irq_init_cfg
  import irq_init_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int MODE_W = 5,
  localparam int BASE_W = DATA_W - BASE_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_first,
  input  logic              ld_base,
  input  logic              ld_casc,
  input  logic              ld_mode,
  input  logic [DATA_W-1:0] wr_data,
  output logic              single_mode,
  output logic              ic4,
  output logic [BASE_W-1:0] vec_base,
  output logic [DATA_W-1:0] cascade_cfg,
  output logic [MODE_W-1:0] mode_bits
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      single_mode <= 1'b0;
      ic4         <= 1'b0;
      vec_base    <= '0;
      cascade_cfg <= '0;
      mode_bits   <= '0;
    end else begin
      if (ld_first) begin
        single_mode <= wr_data[SINGLE_BIT];
        ic4         <= wr_data[IC4_BIT];
        if (!wr_data[IC4_BIT]) mode_bits <= '0;
      end
      if (ld_base) vec_base    <= wr_data[DATA_W-1:BASE_LSB];
      if (ld_casc) cascade_cfg <= wr_data;
      if (ld_mode) mode_bits   <= wr_data[MODE_W-1:0];
    end
  end

  p_mode_cleared_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_first && !wr_data[IC4_BIT]) |=> mode_bits == '0);

  p_base_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_base |=> $stable(vec_base));

  p_casc_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_casc |=> $stable(cascade_cfg));

endmodule

// File: rtl/irq_init_cmd.sv
module irq_init_cmd #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_first,
  input  logic              ld_mask,
  input  logic              ld_cmd,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] mask,
  output logic              cmd_valid,
  output logic [DATA_W-1:0] cmd_data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask      <= '0;
      cmd_valid <= 1'b0;
      cmd_data  <= '0;
    end else begin
      cmd_valid <= ld_cmd;
      if (ld_first)     mask <= '0;
      else if (ld_mask) mask <= wr_data;
      if (ld_cmd) cmd_data <= wr_data;
    end
  end

  p_mask_cleared_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ld_first |=> mask == '0);

  p_mask_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mask) |-> $past(ld_first || ld_mask));

  p_cmd_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $past(ld_cmd));

endmodule

// File: rtl/irq_init_seq.sv
module irq_init_seq
  import irq_init_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int MODE_W = 5,
  localparam int BASE_W = DATA_W - BASE_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              addr0,
  input  logic [DATA_W-1:0] wr_data,
  output logic              ready,
  output logic [BASE_W-1:0] vec_base,
  output logic              single_mode,
  output logic [DATA_W-1:0] cascade_cfg,
  output logic [MODE_W-1:0] mode_bits,
  output logic [DATA_W-1:0] mask,
  output logic              edge_rst_pulse,
  output logic              mode_rst_pulse,
  output logic              ocw_valid,
  output logic [DATA_W-1:0] ocw_data
);

  logic ld_first, ld_base, ld_casc, ld_mode, ld_mask, ld_cmd;
  logic cfg_ic4;

  irq_init_fsm u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_en          (wr_en),
    .addr0          (addr0),
    .init_flag      (wr_data[INIT_FLAG_BIT]),
    .cfg_single     (single_mode),
    .cfg_ic4        (cfg_ic4),
    .ld_first       (ld_first),
    .ld_base        (ld_base),
    .ld_casc        (ld_casc),
    .ld_mode        (ld_mode),
    .ld_mask        (ld_mask),
    .ld_cmd         (ld_cmd),
    .ready          (ready),
    .edge_rst_pulse (edge_rst_pulse),
    .mode_rst_pulse (mode_rst_pulse)
  );

  irq_init_cfg #(.DATA_W(DATA_W), .MODE_W(MODE_W)) u_cfg (
    .clk         (clk),
    .rst_n       (rst_n),
    .ld_first    (ld_first),
    .ld_base     (ld_base),
    .ld_casc     (ld_casc),
    .ld_mode     (ld_mode),
    .wr_data     (wr_data),
    .single_mode (single_mode),
    .ic4         (cfg_ic4),
    .vec_base    (vec_base),
    .cascade_cfg (cascade_cfg),
    .mode_bits   (mode_bits)
  );

  irq_init_cmd #(.DATA_W(DATA_W)) u_cmd (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_first  (ld_first),
    .ld_mask   (ld_mask),
    .ld_cmd    (ld_cmd),
    .wr_data   (wr_data),
    .mask      (mask),
    .cmd_valid (ocw_valid),
    .cmd_data  (ocw_data)
  );

  p_pulses_paired_r5: assert property (@(posedge clk) disable iff (!rst_n)
    edge_rst_pulse == mode_rst_pulse);

  p_cmd_needs_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ocw_valid |-> $past(ready));

endmodule

// File: tb/irq_init_seq_test.sv
`timescale 1ns/1ps
module irq_init_seq_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic       addr0;
  logic [7:0] wr_data;
  logic       ready, single_mode, edge_rst_pulse, mode_rst_pulse, ocw_valid;
  logic [4:0] vec_base, mode_bits;
  logic [7:0] cascade_cfg, mask, ocw_data;

  int vectors = 0;
  int fails   = 0;

  // reference model state: 0 uninit, 2..4 expecting byte n, 5 ready
  int m_state, m_single, m_ic4, m_base, m_casc, m_mode, m_mask;
  int m_pulse, m_ocwv, m_ocwd;

  always #2 clk = ~clk;

  irq_init_seq uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr0(addr0), .wr_data(wr_data),
    .ready(ready), .vec_base(vec_base), .single_mode(single_mode),
    .cascade_cfg(cascade_cfg), .mode_bits(mode_bits), .mask(mask),
    .edge_rst_pulse(edge_rst_pulse), .mode_rst_pulse(mode_rst_pulse),
    .ocw_valid(ocw_valid), .ocw_data(ocw_data)
  );

  task automatic cmp(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    cmp("R6 ready",        ready,          (m_state == 5));
    cmp("R2 vec_base",     vec_base,       m_base);
    cmp("R3 single_mode",  single_mode,    m_single);
    cmp("R3 cascade_cfg",  cascade_cfg,    m_casc);
    cmp("R4 mode_bits",    mode_bits,      m_mode);
    cmp("R8 mask",         mask,           m_mask);
    cmp("R5 edge pulse",   edge_rst_pulse, m_pulse);
    cmp("R5 mode pulse",   mode_rst_pulse, m_pulse);
    cmp("R7 ocw_valid",    ocw_valid,      m_ocwv);
    cmp("R7 ocw_data",     ocw_data,       m_ocwd);
  endtask

  // one clock: compare at the falling edge, then drive and advance the model
  task automatic apply(input bit w, input bit a, input bit [7:0] d);
    @(negedge clk);
    compare_all();
    wr_en = w; addr0 = a; wr_data = d;
    m_pulse = 0;
    m_ocwv  = 0;
    if (w) begin
      if (!a && d[4]) begin
        m_state  = 2;
        m_single = d[1];
        m_ic4    = d[0];
        if (m_ic4 == 0) m_mode = 0;
        m_mask   = 0;
        m_pulse  = 1;
      end else if (a) begin
        case (m_state)
          2: begin
            m_base = d / 8;
            if (m_single == 0) m_state = 3;
            else m_state = m_ic4 ? 4 : 5;
          end
          3: begin m_casc = d; m_state = m_ic4 ? 4 : 5; end
          4: begin m_mode = d % 32; m_state = 5; end
          5: m_mask = d;
          default: ;
        endcase
      end else if (m_state == 5) begin
        m_ocwv = 1;
        m_ocwd = d;
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) apply(0, 0, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; addr0 = 1'b0; wr_data = 8'h00;
    m_state = 0; m_single = 0; m_ic4 = 0; m_base = 0; m_casc = 0;
    m_mode = 0; m_mask = 0; m_pulse = 0; m_ocwv = 0; m_ocwd = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    cmp("R10 ready", ready, 0);
    cmp("R10 mask", mask, 0);
    cmp("R10 vec_base", vec_base, 0);
    cmp("R10 ocw_valid", ocw_valid, 0);

    // R9: ignored before any start byte
    apply(1, 1, 8'h55);
    apply(1, 0, 8'h05);
    idle(1);
    cmp("R9 mask untouched", mask, 0);
    cmp("R9 ready low", ready, 0);
    cmp("R9 no command", ocw_valid, 0);

    // single, final byte requested: 3 bytes
    apply(1, 0, 8'h13);
    apply(1, 0, 8'h08);            // R9 ignored during sequence
    apply(1, 1, 8'hA8);
    apply(1, 1, 8'h1F);
    idle(1);
    cmp("R6 ready after 3 bytes", ready, 1);
    cmp("R2 base A8", vec_base, 5'h15);
    cmp("R4 mode 1F", mode_bits, 5'h1F);

    // R8 / R7 in ready state
    apply(1, 1, 8'hC3);
    apply(1, 0, 8'h20);
    apply(1, 0, 8'h0B);
    idle(1);
    cmp("R8 mask loaded", mask, 8'hC3);
    cmp("R7 last command", ocw_data, 8'h0B);

    // R1 restart from ready: cascaded, no final byte (3 bytes)
    apply(1, 0, 8'h10);
    idle(1);
    cmp("R1 ready dropped", ready, 0);
    cmp("R5 mask cleared", mask, 0);
    cmp("R4 mode cleared", mode_bits, 0);
    apply(1, 0, 8'h00);            // R9 ignored during sequence
    apply(1, 1, 8'h40);
    apply(1, 1, 8'h04);
    idle(2);
    cmp("R3 cascade byte", cascade_cfg, 8'h04);

    // cascaded with final byte: 4 bytes
    apply(1, 0, 8'h11);
    apply(1, 1, 8'hF8);
    apply(1, 1, 8'h81);
    idle(1);
    cmp("R6 not ready before final byte", ready, 0);
    apply(1, 1, 8'h02);
    apply(1, 1, 8'h7E);
    apply(1, 0, 8'h6C);
    idle(2);

    // single, no final byte: 2 bytes
    apply(1, 0, 8'h12);
    apply(1, 1, 8'h30);
    idle(1);
    cmp("R6 ready after 2 bytes", ready, 1);

    // R1 restart in the middle of a sequence
    apply(1, 0, 8'h11);
    apply(1, 1, 8'h88);
    apply(1, 0, 8'h1A);
    apply(1, 1, 8'h50);
    idle(1);
    cmp("R1 restarted sequence ready", ready, 1);
    cmp("R2 base after restart", vec_base, 5'h0A);
    idle(2);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule